// File: doc/BRIEF.md
# Loop and Repeat Counter Unit

This unit sits next to the on-deck stage of an instruction queue and holds the iteration state that stage consults. It has a loop counter, a repeat counter and a 37-bit data latch with a separate flag bit. Each cycle it may receive one decoded instruction with a strobe. A predicate-derived enable says whether that instruction takes effect. The unit then performs the counter or latch update that the instruction asks for.

The loop counter has three load modes: a literal, the low latch bits, or a decrement that stops at zero. The repeat counter loads from a literal or from the latch. It also counts down once each time an instruction classed as repeating goes round again. Either counter can be copied into the latch's low bits without disturbing the rest of the latch. The counter values and their zero flags go out to the queue logic. An abort clear forces the loop counter to zero.

Top module: `loopctr_unit`

## Requirements
- R1: After reset both counters read 0, both zero flags read 1, the latch reads all zeros and the flag bit reads 0.
- R2: Op code 3 with strobe and enable loads the loop counter from literal bits 5:0, visible after the next rising edge.
- R3: Op code 2 with strobe and enable loads the loop counter from latch bits 5:0.
- R4: Op code 1 with strobe and enable replaces the loop counter with max(0, count-1); it never wraps.
- R5: When lc_clear is high, the loop counter is 0 after the edge, whatever loop load is issued in the same cycle.
- R6: Op code 4 loads the repeat counter from literal bits 5:0; op code 5 loads it from latch bits 5:0.
- R7: An executed instruction with op_repeats high drives rpt_again high in the same cycle when the repeat counter is nonzero, and the counter drops by exactly one. When the counter is zero, rpt_again stays low and the counter stays 0.
- R8: An executed instruction that is neither repeating nor a repeat-counter load leaves the repeat counter unchanged.
- R9: Op code 6 writes literal bits 17:0 into latch bits 36:19 and copies literal bit 17 into the flag. Latch bits 18:0 are unchanged.
- R10: Op code 7 writes literal bits 18:0 into latch bits 18:0. Latch bits 36:19 and the flag are unchanged.
- R11: Op code 8 loads the whole latch with the 19-bit literal sign-extended from its bit 18, and sets the flag to literal bit 18.
- R12: Op code 9 (10) copies the loop (repeat) counter into latch bits 5:0. All other latch bits and the flag are unchanged.
- R13: With exec_en low or op_valid low, no counter or latch changes and rpt_again is low.
- R14: Each zero flag equals (counter == 0) on every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Strobe: a decoded instruction is present this cycle |
| exec_en | input | 1 | Predicate result: 1 means the instruction executes |
| op_code | input | 4 | Decoded operation (codes listed in the requirements; others do nothing) |
| op_repeats | input | 1 | Instruction is classed as repeating |
| literal | input | 19 | Literal field of the instruction |
| lc_clear | input | 1 | Abort clear for the loop counter, wins over loads |
| rpt_again | output | 1 | Combinational: the present repeating instruction goes round again |
| lc_value | output | 6 | Loop counter |
| lc_zero | output | 1 | Loop counter is zero |
| rc_value | output | 6 | Repeat counter |
| rc_zero | output | 1 | Repeat counter is zero |
| latch_value | output | 37 | Data latch |
| latch_flag | output | 1 | Flag bit of the data latch |

## Verification
The assertions check on every cycle that the zero flags track the counters and that the clear wins over loads. They also check that a decrement at zero stays at zero, that an idle counter holds, that partial latch writes keep the untouched half and the flag, and that rpt_again never rises on an empty repeat counter. Only the directed scenarios can show the exact values that reach the counters and the latch. Those values are the literal slicing, the sign extension, the latch-to-counter paths, the step-by-step repeat countdown and the effect of a cleared predicate, and each is checked against values the bench works out from the requirements.

// File: rtl/loopctr_pkg.sv
package loopctr_pkg;

  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_LOOP_DEC   = 4'd1,
    OP_LOOP_LATCH = 4'd2,
    OP_LOOP_LIT   = 4'd3,
    OP_RPT_LIT    = 4'd4,
    OP_RPT_LATCH  = 4'd5,
    OP_LATCH_HI   = 4'd6,
    OP_LATCH_LO   = 4'd7,
    OP_LATCH_FULL = 4'd8,
    OP_TAKE_LC    = 4'd9,
    OP_TAKE_RC    = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    CSEL_NONE  = 2'd0,
    CSEL_DEC   = 2'd1,
    CSEL_LATCH = 2'd2,
    CSEL_LIT   = 2'd3
  } cnt_sel_e;

  typedef enum logic [2:0] {
    LSEL_NONE    = 3'd0,
    LSEL_HI      = 3'd1,
    LSEL_LO      = 3'd2,
    LSEL_FULL    = 3'd3,
    LSEL_TAKE_LC = 3'd4,
    LSEL_TAKE_RC = 3'd5
  } lat_sel_e;

  typedef struct packed {
    logic     fire;
    cnt_sel_e lc_sel;
    cnt_sel_e rc_sel;
    lat_sel_e lat_sel;
  } ctl_t;

endpackage

// File: rtl/loopctr_decode.sv
module loopctr_decode
  import loopctr_pkg::*;
(
  input  logic       op_valid,
  input  logic       exec_en,
  input  logic [3:0] op_code,
  output ctl_t       ctl
);

  op_e op;
  assign op = op_e'(op_code);

  always_comb begin
    ctl.fire    = op_valid & exec_en;
    ctl.lc_sel  = CSEL_NONE;
    ctl.rc_sel  = CSEL_NONE;
    ctl.lat_sel = LSEL_NONE;
    if (op_valid && exec_en) begin
      case (op)
        OP_LOOP_DEC:   ctl.lc_sel  = CSEL_DEC;
        OP_LOOP_LATCH: ctl.lc_sel  = CSEL_LATCH;
        OP_LOOP_LIT:   ctl.lc_sel  = CSEL_LIT;
        OP_RPT_LIT:    ctl.rc_sel  = CSEL_LIT;
        OP_RPT_LATCH:  ctl.rc_sel  = CSEL_LATCH;
        OP_LATCH_HI:   ctl.lat_sel = LSEL_HI;
        OP_LATCH_LO:   ctl.lat_sel = LSEL_LO;
        OP_LATCH_FULL: ctl.lat_sel = LSEL_FULL;
        OP_TAKE_LC:    ctl.lat_sel = LSEL_TAKE_LC;
        OP_TAKE_RC:    ctl.lat_sel = LSEL_TAKE_RC;
        default:       ;
      endcase
    end
  end

endmodule

// File: rtl/loopctr_count.sv
module loopctr_count
  import loopctr_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  cnt_sel_e         sel,
  input  logic             ext_dec,
  input  logic [CNT_W-1:0] lit_val,
  input  logic [CNT_W-1:0] lat_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             zero_d;
  logic             upd;
  logic             want_dec;

  assign want_dec = (sel == CSEL_DEC) | ext_dec;

  always_comb begin
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (clr) begin
      cnt_d = '0;
      upd   = 1'b1;
    end else if (sel == CSEL_LIT) begin
      cnt_d = lit_val;
      upd   = 1'b1;
    end else if (sel == CSEL_LATCH) begin
      cnt_d = lat_val;
      upd   = 1'b1;
    end else if (want_dec) begin
      cnt_d = zero_q ? '0 : (cnt_q - ONE);
      upd   = 1'b1;
    end
    zero_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      zero_q <= 1'b1;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      zero_q <= zero_d;
    end
  end

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sel == CSEL_DEC && cnt_q == '0) |=> (cnt_q == '0));

  p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sel == CSEL_NONE && ext_dec && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sel == CSEL_NONE && !ext_dec) |=> $stable(cnt_q));

  p_zero_flag_r14: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q == (cnt_q == '0));

endmodule

// File: rtl/loopctr_latch.sv
module loopctr_latch
  import loopctr_pkg::*;
#(
  parameter int DATA_W = 37,
  parameter int LIT_W  = 19,
  parameter int LC_W   = 6,
  parameter int RC_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lat_sel_e          sel,
  input  logic [LIT_W-1:0]  lit,
  input  logic [LC_W-1:0]   lc_val,
  input  logic [RC_W-1:0]   rc_val,
  output logic [DATA_W-1:0] latch_q,
  output logic              flag_q
);

  localparam int HI_W = DATA_W - LIT_W;
  localparam int EXT_W = DATA_W - LIT_W;

  logic [DATA_W-1:0] latch_d;
  logic              flag_d;
  logic              upd;

  always_comb begin
    latch_d = latch_q;
    flag_d  = flag_q;
    upd     = 1'b1;
    case (sel)
      LSEL_HI: begin
        latch_d[DATA_W-1 -: HI_W] = lit[HI_W-1:0];
        flag_d                    = lit[HI_W-1];
      end
      LSEL_LO: begin
        latch_d[LIT_W-1:0] = lit;
      end
      LSEL_FULL: begin
        latch_d = {{EXT_W{lit[LIT_W-1]}}, lit};
        flag_d  = lit[LIT_W-1];
      end
      LSEL_TAKE_LC: begin
        latch_d[LC_W-1:0] = lc_val;
      end
      LSEL_TAKE_RC: begin
        latch_d[RC_W-1:0] = rc_val;
      end
      default: upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      flag_q  <= 1'b0;
    end else if (upd) begin
      latch_q <= latch_d;
      flag_q  <= flag_d;
    end
  end

  p_hi_keeps_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == LSEL_HI) |=> $stable(latch_q[LIT_W-1:0]) && (flag_q == $past(lit[HI_W-1])));

  p_lo_keeps_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == LSEL_LO) |=> $stable(latch_q[DATA_W-1:LIT_W]) && $stable(flag_q));

  p_take_lc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == LSEL_TAKE_LC) |=> $stable(latch_q[DATA_W-1:LC_W]) && $stable(flag_q)
                              && (latch_q[LC_W-1:0] == $past(lc_val)));

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == LSEL_NONE) |=> $stable(latch_q) && $stable(flag_q));

endmodule

// File: rtl/loopctr_unit.sv
module loopctr_unit
  import loopctr_pkg::*;
#(
  parameter int DATA_W = 37,
  parameter int LIT_W  = 19,
  parameter int LC_W   = 6,
  parameter int RC_W   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              exec_en,
  input  logic [3:0]        op_code,
  input  logic              op_repeats,
  input  logic [LIT_W-1:0]  literal,
  input  logic              lc_clear,
  output logic              rpt_again,
  output logic [LC_W-1:0]   lc_value,
  output logic              lc_zero,
  output logic [RC_W-1:0]   rc_value,
  output logic              rc_zero,
  output logic [DATA_W-1:0] latch_value,
  output logic              latch_flag
);

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync[SYNC_STAGES-1];

  ctl_t ctl;
  logic rc_step;

  loopctr_decode u_dec (
    .op_valid (op_valid),
    .exec_en  (exec_en),
    .op_code  (op_code),
    .ctl      (ctl)
  );

  assign rc_step   = ctl.fire & op_repeats & (ctl.rc_sel == CSEL_NONE) & ~rc_zero;
  assign rpt_again = rc_step;

  loopctr_count #(.CNT_W(LC_W)) u_lc (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .clr     (lc_clear),
    .sel     (ctl.lc_sel),
    .ext_dec (1'b0),
    .lit_val (literal[LC_W-1:0]),
    .lat_val (latch_value[LC_W-1:0]),
    .cnt_q   (lc_value),
    .zero_q  (lc_zero)
  );

  loopctr_count #(.CNT_W(RC_W)) u_rc (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .clr     (1'b0),
    .sel     (ctl.rc_sel),
    .ext_dec (rc_step),
    .lit_val (literal[RC_W-1:0]),
    .lat_val (latch_value[RC_W-1:0]),
    .cnt_q   (rc_value),
    .zero_q  (rc_zero)
  );

  loopctr_latch #(
    .DATA_W (DATA_W),
    .LIT_W  (LIT_W),
    .LC_W   (LC_W),
    .RC_W   (RC_W)
  ) u_latch (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .sel     (ctl.lat_sel),
    .lit     (literal),
    .lc_val  (lc_value),
    .rc_val  (rc_value),
    .latch_q (latch_value),
    .flag_q  (latch_flag)
  );

  p_again_needs_count_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    rpt_again |-> (rc_value != '0));

  p_ignored_quiet_r13: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!exec_en || !op_valid) |-> !rpt_again);

endmodule

// File: tb/loopctr_unit_bench.sv
`timescale 1ns/1ps
module loopctr_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, exec_en, op_repeats, lc_clear;
  logic [3:0]  op_code;
  logic [18:0] literal;
  logic        rpt_again;
  logic [5:0]  lc_value, rc_value;
  logic        lc_zero, rc_zero;
  logic [36:0] latch_value;
  logic        latch_flag;

  int checks = 0;
  int errors = 0;
  logic [36:0] exp_latch;
  logic        exp_flag;
  logic        seen_again;

  always #2.5 clk = ~clk;

  loopctr_unit u_loopctr_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .exec_en(exec_en),
    .op_code(op_code), .op_repeats(op_repeats), .literal(literal),
    .lc_clear(lc_clear), .rpt_again(rpt_again), .lc_value(lc_value),
    .lc_zero(lc_zero), .rc_value(rc_value), .rc_zero(rc_zero),
    .latch_value(latch_value), .latch_flag(latch_flag)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, capture rpt_again, let one rising edge pass, go idle.
  task automatic issue(input logic [3:0] op, input logic [18:0] lit,
                       input logic rep, input logic en, input logic vld, input logic clr);
    @(negedge clk);
    op_code = op; literal = lit; op_repeats = rep; exec_en = en;
    op_valid = vld; lc_clear = clr;
    #1 seen_again = rpt_again;
    @(posedge clk);
    #1;
    op_valid = 1'b0; exec_en = 1'b0; op_repeats = 1'b0; lc_clear = 1'b0;
    op_code = 4'd0; literal = '0;
  endtask

  task automatic t_reset;
    chk("R1 lc", lc_value, 0);
    chk("R1 rc", rc_value, 0);
    chk("R1 latch", latch_value, 0);
    chk("R1 flag", latch_flag, 0);
    chk("R14 lc_zero", lc_zero, 1);
    chk("R14 rc_zero", rc_zero, 1);
  endtask

  task automatic t_latch_loads;
    logic [18:0] v;
    v = 19'h40005;
    issue(4'd8, v, 0, 1, 1, 0);
    exp_latch = {{18{1'b1}}, v}; exp_flag = 1'b1;
    chk("R11 latch", latch_value, exp_latch);
    chk("R11 flag", latch_flag, exp_flag);
    v = 19'h00012;
    issue(4'd6, v, 0, 1, 1, 0);
    exp_latch[36:19] = v[17:0]; exp_flag = v[17];
    chk("R9 latch", latch_value, exp_latch);
    chk("R9 flag", latch_flag, exp_flag);
    v = 19'h2002A;
    issue(4'd6, v, 0, 1, 1, 0);
    exp_latch[36:19] = v[17:0]; exp_flag = v[17];
    chk("R9 flag set", latch_flag, 1);
    chk("R9 latch2", latch_value, exp_latch);
    v = 19'h0002A;
    issue(4'd7, v, 0, 1, 1, 0);
    exp_latch[18:0] = v;
    chk("R10 latch", latch_value, exp_latch);
    chk("R10 flag", latch_flag, exp_flag);
  endtask

  task automatic t_loop_lit_dec;
    issue(4'd3, 19'h7FF03, 0, 1, 1, 0);
    chk("R2 lc", lc_value, 3);
    chk("R14 lc_zero", lc_zero, 0);
    for (int i = 2; i >= -1; i--) begin
      issue(4'd1, '0, 0, 1, 1, 0);
      chk("R4 lc", lc_value, (i < 0) ? 0 : i);
      chk("R14 lc_zero", lc_zero, (i <= 0) ? 1 : 0);
    end
  endtask

  task automatic t_loop_latch;
    issue(4'd2, 19'h00001, 0, 1, 1, 0);
    chk("R3 lc", lc_value, exp_latch[5:0]);
  endtask

  task automatic t_clear;
    issue(4'd3, 19'h00009, 0, 1, 1, 1);
    chk("R5 clear over load", lc_value, 0);
    chk("R14 lc_zero", lc_zero, 1);
    issue(4'd3, 19'h00009, 0, 1, 1, 0);
    issue(4'd0, '0, 0, 0, 0, 1);
    chk("R5 clear alone", lc_value, 0);
  endtask

  task automatic t_repeat;
    issue(4'd4, 19'h00002, 0, 1, 1, 0);
    chk("R6 rc lit", rc_value, 2);
    issue(4'd0, '0, 1, 1, 1, 0);
    chk("R7 again 1", seen_again, 1);
    chk("R7 rc 1", rc_value, 1);
    issue(4'd0, '0, 1, 1, 1, 0);
    chk("R7 again 2", seen_again, 1);
    chk("R7 rc 0", rc_value, 0);
    chk("R14 rc_zero", rc_zero, 1);
    issue(4'd0, '0, 1, 1, 1, 0);
    chk("R7 no again at 0", seen_again, 0);
    chk("R7 rc stays 0", rc_value, 0);
    issue(4'd5, '0, 0, 1, 1, 0);
    chk("R6 rc latch", rc_value, exp_latch[5:0]);
    issue(4'd7, 19'h00015, 0, 1, 1, 0);
    exp_latch[18:0] = 19'h00015;
    chk("R8 rc unchanged", rc_value, 6'h2A);
  endtask

  task automatic t_take;
    issue(4'd3, 19'h00011, 0, 1, 1, 0);
    issue(4'd9, '0, 0, 1, 1, 0);
    exp_latch[5:0] = 6'h11;
    chk("R12 take lc", latch_value, exp_latch);
    chk("R12 flag", latch_flag, exp_flag);
    issue(4'd10, '0, 0, 1, 1, 0);
    exp_latch[5:0] = 6'h2A;
    chk("R12 take rc", latch_value, exp_latch);
  endtask

  task automatic t_ignored;
    issue(4'd3, 19'h00007, 0, 0, 1, 0);
    chk("R13 lc no exec", lc_value, 6'h11);
    issue(4'd0, '0, 1, 0, 1, 0);
    chk("R13 no again", seen_again, 0);
    chk("R13 rc", rc_value, 6'h2A);
    issue(4'd8, 19'h7FFFF, 1, 1, 0, 0);
    chk("R13 latch no strobe", latch_value, exp_latch);
    chk("R13 rc no strobe", rc_value, 6'h2A);
    chk("R13 again no strobe", seen_again, 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 0; exec_en = 0; op_repeats = 0; lc_clear = 0;
    op_code = '0; literal = '0; exp_latch = '0; exp_flag = 0; seen_again = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_latch_loads();
    t_loop_lit_dec();
    t_loop_latch();
    t_clear();
    t_repeat();
    t_take();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule